// File: doc/BRIEF.md
# Debug Command Sequencer

This block sits between a byte-serial debug host link and a processor core. The host pushes bytes over a valid/ready stream and marks the first byte of each command with a frame-start flag. The block decodes that opcode byte and runs one of two commands. The first is a program-counter synchronization request. It does not stop the core: the block raises a request line and holds it until the core acknowledges. The second is a control-register write. It is allowed only while the core is halted. The block gathers four operand bytes, most significant first, and hands the core one 32-bit write strobe together with the register number taken from the opcode.

Opcodes the block does not know, and register writes that arrive while the core is running, are rejected. A sticky illegal flag is set and the rest of the frame is dropped. Every command outcome ends with a one-cycle done pulse: a finished sync, a finished write, or a rejection. A busy line tells the host that a command is still in progress.

Top module: `dbg_cmd_seq`

## Requirements
- R1: After reset, sync_req, busy, illegal, done and creg_we are 0 and in_ready is 1.
- R2: An accepted byte 0x01 with frame_start high raises sync_req and busy in the next cycle, whatever core_halted is. While sync_req is high, in_ready is 0.
- R3: sync_req stays high until a cycle with sync_ack high. At that edge sync_req and busy fall, and done pulses for exactly one cycle.
- R4: An accepted frame-start byte with bits 7:6 = 11, taken while core_halted is 1, starts a write. The next four accepted non-frame bytes form creg_data, first byte in bits 31:24 and last in 7:0. After the edge that accepts the fourth byte, creg_we and done are high for one cycle, and creg_num equals opcode bits 5:0.
- R5: A write opcode accepted while core_halted is 0 sets illegal and pulses done. It produces no creg_we, and the operand bytes that follow are ignored.
- R6: Any other opcode (not 0x01, bits 7:6 not 11) sets illegal and pulses done. The following non-frame bytes are ignored.
- R7: illegal stays set until the next accepted valid opcode (sync, or write while halted), which clears it.
- R8: A frame-start byte that arrives during operand collection abandons the write with no strobe and is decoded as a new opcode.
- R9: core_halted is sampled only with the opcode byte. A write that started while halted completes even if core_halted drops during its operands.
- R10: Non-frame bytes received while no command is in progress change no output.
- R11: sync_ack while no sync is pending has no effect on any output.
- R12: busy is high from the edge that accepts a valid write opcode until the edge that accepts its last operand byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Host byte valid |
| in_data | input | 8 | Host byte |
| in_frame | input | 1 | Byte is an opcode (frame start) |
| in_ready | output | 1 | Block can take a byte |
| core_halted | input | 1 | Core is halted |
| sync_ack | input | 1 | Core has taken the sync request |
| sync_req | output | 1 | PC synchronization request pending |
| creg_we | output | 1 | One-cycle control-register write strobe |
| creg_num | output | 6 | Register number of the write |
| creg_data | output | 32 | Write data |
| busy | output | 1 | Command in progress |
| illegal | output | 1 | Sticky rejection flag |
| done | output | 1 | One-cycle command completion pulse |

## Verification
The assertions assume that sync_ack is meaningful only while a request is pending. They also assume that the host leaves in_data and in_frame alone except on accepted beats. The bench drives every byte on the falling edge and holds it for exactly one rising edge. It raises sync_ack only as a single-cycle pulse. It changes core_halted only between bytes, so the halt sampled with each opcode is known in advance.

// File: rtl/dbg_cmd_pkg.sv
package dbg_cmd_pkg;
    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COLLECT,
        ST_SYNC,
        ST_DISCARD
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_SYNC,
        OP_WRITE,
        OP_BAD
    } op_kind_e;
endpackage

// File: rtl/dbg_opc_decode.sv
module dbg_opc_decode
    import dbg_cmd_pkg::*;
#(
    parameter int unsigned CRN_W    = 6,
    parameter logic [7:0]  SYNC_OPC = 8'h01
) (
    input  logic [BYTE_W-1:0] opc,
    output op_kind_e          kind,
    output logic [CRN_W-1:0]  crn
);
    localparam int unsigned PFX_W = BYTE_W - CRN_W;

    always_comb begin
        crn = opc[CRN_W-1:0];
        if (opc == SYNC_OPC) begin
            kind = OP_SYNC;
        end else if (opc[BYTE_W-1:CRN_W] == {PFX_W{1'b1}}) begin
            kind = OP_WRITE;
        end else begin
            kind = OP_BAD;
        end
    end
endmodule

// File: rtl/dbg_operand_shift.sv
module dbg_operand_shift
    import dbg_cmd_pkg::*;
#(
    parameter int unsigned BYTES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear,
    input  logic                     shift_en,
    input  logic [BYTE_W-1:0]        byte_in,
    output logic [BYTES*BYTE_W-1:0]  word,
    output logic                     last
);
    localparam int unsigned W     = BYTES * BYTE_W;
    localparam int unsigned CNT_W = (BYTES > 1) ? $clog2(BYTES) : 1;

    typedef struct packed {
        logic [W-1:0]     word;
        logic [CNT_W-1:0] cnt;
    } sh_t;

    sh_t sh_d, sh_q;

    assign word = sh_q.word;
    assign last = (sh_q.cnt == CNT_W'(BYTES - 1));

    always_comb begin
        sh_d = sh_q;
        if (clear) begin
            sh_d.cnt = '0;
        end else if (shift_en) begin
            sh_d.word = (sh_q.word << BYTE_W) | W'(byte_in);
            sh_d.cnt  = last ? '0 : sh_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
    import dbg_cmd_pkg::*;
#(
    parameter int unsigned OPERAND_BYTES = 4,
    parameter int unsigned CRN_W         = 6,
    parameter logic [7:0]  SYNC_OPC      = 8'h01
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            in_valid,
    input  logic [7:0]                      in_data,
    input  logic                            in_frame,
    output logic                            in_ready,
    input  logic                            core_halted,
    input  logic                            sync_ack,
    output logic                            sync_req,
    output logic                            creg_we,
    output logic [CRN_W-1:0]                creg_num,
    output logic [OPERAND_BYTES*8-1:0]      creg_data,
    output logic                            busy,
    output logic                            illegal,
    output logic                            done
);
    typedef struct packed {
        seq_state_e       state;
        logic             illegal;
        logic             done;
        logic             we;
        logic [CRN_W-1:0] crn;
    } seq_t;

    seq_t s_d, s_q;

    op_kind_e         dec_kind;
    logic [CRN_W-1:0] dec_crn;
    logic             accept;
    logic             sh_clr;
    logic             sh_en;
    logic             sh_last;

    dbg_opc_decode #(
        .CRN_W    (CRN_W),
        .SYNC_OPC (SYNC_OPC)
    ) u_dec (
        .opc  (in_data),
        .kind (dec_kind),
        .crn  (dec_crn)
    );

    dbg_operand_shift #(
        .BYTES (OPERAND_BYTES)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (sh_clr),
        .shift_en (sh_en),
        .byte_in  (in_data),
        .word     (creg_data),
        .last     (sh_last)
    );

    assign in_ready = (s_q.state != ST_SYNC);
    assign accept   = in_valid && in_ready;
    assign sync_req = (s_q.state == ST_SYNC);
    assign busy     = (s_q.state == ST_SYNC) || (s_q.state == ST_COLLECT);
    assign illegal  = s_q.illegal;
    assign done     = s_q.done;
    assign creg_we  = s_q.we;
    assign creg_num = s_q.crn;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.we   = 1'b0;
        sh_clr   = 1'b0;
        sh_en    = 1'b0;
        if (accept && in_frame) begin
            unique case (dec_kind)
                OP_SYNC: begin
                    s_d.state   = ST_SYNC;
                    s_d.illegal = 1'b0;
                end
                OP_WRITE: begin
                    if (core_halted) begin
                        s_d.state   = ST_COLLECT;
                        s_d.illegal = 1'b0;
                        s_d.crn     = dec_crn;
                        sh_clr      = 1'b1;
                    end else begin
                        s_d.state   = ST_DISCARD;
                        s_d.illegal = 1'b1;
                        s_d.done    = 1'b1;
                    end
                end
                default: begin
                    s_d.state   = ST_DISCARD;
                    s_d.illegal = 1'b1;
                    s_d.done    = 1'b1;
                end
            endcase
        end else begin
            unique case (s_q.state)
                ST_COLLECT: begin
                    if (accept) begin
                        sh_en = 1'b1;
                        if (sh_last) begin
                            s_d.we    = 1'b1;
                            s_d.done  = 1'b1;
                            s_d.state = ST_IDLE;
                        end
                    end
                end
                ST_SYNC: begin
                    if (sync_ack) begin
                        s_d.state = ST_IDLE;
                        s_d.done  = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state   <= ST_IDLE;
            s_q.illegal <= 1'b0;
            s_q.done    <= 1'b0;
            s_q.we      <= 1'b0;
            s_q.crn     <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    a_r4_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        creg_we |=> !creg_we);
    a_r4_we_done: assert property (@(posedge clk) disable iff (!rst_n)
        creg_we |-> done);
    a_r12_we_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(creg_we) |-> $past(busy) && !busy);
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req && !sync_ack |=> sync_req);
    a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req && sync_ack |=> !sync_req && done);
    a_r2_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        sync_req |-> !in_ready);
    a_r5_illegal_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(illegal) |-> done && !creg_we);
    a_r7_illegal_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        illegal && !(in_valid && in_frame) |=> illegal);
endmodule

// File: tb/dbg_cmd_seq_test.sv
`timescale 1ns/1ps
module dbg_cmd_seq_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_frame = 1'b0;
    logic        in_ready;
    logic        core_halted = 1'b0;
    logic        sync_ack = 1'b0;
    logic        sync_req;
    logic        creg_we;
    logic [5:0]  creg_num;
    logic [31:0] creg_data;
    logic        busy;
    logic        illegal;
    logic        done;

    int n_checks = 0;
    int n_fail   = 0;
    int we_count = 0;

    always #10 clk = ~clk;

    dbg_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_frame(in_frame), .in_ready(in_ready), .core_halted(core_halted),
        .sync_ack(sync_ack), .sync_req(sync_req), .creg_we(creg_we),
        .creg_num(creg_num), .creg_data(creg_data), .busy(busy),
        .illegal(illegal), .done(done)
    );

    always @(posedge clk) if (rst_n && creg_we) we_count <= we_count + 1;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic put(input logic fr, input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_frame = fr; in_data = b;
        @(posedge clk); #2;
        in_valid = 1'b0; in_frame = 1'b0;
    endtask

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic ack_sync();
        @(negedge clk); sync_ack = 1'b1;
        @(posedge clk); #2; sync_ack = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 sync_req", sync_req, 0);
        check("R1 busy", busy, 0);
        check("R1 illegal", illegal, 0);
        check("R1 done", done, 0);
        check("R1 creg_we", creg_we, 0);
        check("R1 in_ready", in_ready, 1);
    endtask

    task automatic t_sync(input logic halted);
        core_halted = halted;
        put(1'b1, 8'h01);
        check("R2 sync_req", sync_req, 1);
        check("R2 busy", busy, 1);
        check("R2 in_ready", in_ready, 0);
        tick(); tick();
        check("R3 hold", sync_req, 1);
        check("R3 no early done", done, 0);
        ack_sync();
        check("R3 release", sync_req, 0);
        check("R3 busy clear", busy, 0);
        check("R3 done pulse", done, 1);
        tick();
        check("R3 done one cycle", done, 0);
    endtask

    task automatic t_write(input logic [5:0] crn, input logic [31:0] w);
        int base;
        base = we_count;
        core_halted = 1'b1;
        put(1'b1, {2'b11, crn});
        check("R12 busy after opcode", busy, 1);
        check("R7 illegal cleared", illegal, 0);
        for (int i = 3; i >= 1; i--) begin
            put(1'b0, w[i*8 +: 8]);
            check("R4 no early strobe", creg_we, 0);
        end
        put(1'b0, w[7:0]);
        check("R4 strobe", creg_we, 1);
        check("R4 done", done, 1);
        check("R4 data", creg_data, w);
        check("R4 crn", {26'd0, creg_num}, {26'd0, crn});
        check("R12 busy drops", busy, 0);
        tick();
        check("R4 strobe one cycle", creg_we, 0);
        check("R4 one strobe", we_count - base, 1);
    endtask

    task automatic t_write_rejected();
        int base;
        base = we_count;
        core_halted = 1'b0;
        put(1'b1, 8'hC3);
        check("R5 illegal", illegal, 1);
        check("R5 done", done, 1);
        check("R5 not busy", busy, 0);
        core_halted = 1'b1;
        for (int i = 0; i < 5; i++) put(1'b0, 8'h5A + 8'(i));
        tick();
        check("R5 no strobe", we_count - base, 0);
        check("R7 sticky", illegal, 1);
    endtask

    task automatic t_unknown(input logic [7:0] opc);
        int base;
        base = we_count;
        put(1'b1, opc);
        check("R6 illegal", illegal, 1);
        check("R6 done", done, 1);
        for (int i = 0; i < 4; i++) put(1'b0, 8'hEE);
        check("R6 ignored", we_count - base, 0);
        check("R6 idle", busy, 0);
    endtask

    task automatic t_clear_by_sync();
        put(1'b1, 8'h01);
        check("R7 cleared by sync", illegal, 0);
        ack_sync();
    endtask

    task automatic t_abort();
        int base;
        base = we_count;
        core_halted = 1'b1;
        put(1'b1, 8'hCF);
        put(1'b0, 8'h11);
        put(1'b0, 8'h22);
        put(1'b1, 8'hC5);
        check("R8 no strobe on abort", we_count - base, 0);
        check("R8 busy new write", busy, 1);
        put(1'b0, 8'hDE); put(1'b0, 8'hAD); put(1'b0, 8'hBE); put(1'b0, 8'hEF);
        check("R8 new strobe", creg_we, 1);
        check("R8 new data", creg_data, 32'hDEADBEEF);
        check("R8 new crn", {26'd0, creg_num}, 32'd5);
        tick();
    endtask

    task automatic t_halt_drop();
        core_halted = 1'b1;
        put(1'b1, 8'hFF);
        core_halted = 1'b0;
        put(1'b0, 8'h01); put(1'b0, 8'h02); put(1'b0, 8'h03); put(1'b0, 8'h04);
        check("R9 strobe despite run", creg_we, 1);
        check("R9 data", creg_data, 32'h01020304);
        check("R9 crn", {26'd0, creg_num}, 32'd63);
        tick();
    endtask

    task automatic t_idle_bytes();
        int base;
        base = we_count;
        for (int i = 0; i < 3; i++) begin
            put(1'b0, 8'h01);
            check("R10 done", done, 0);
            check("R10 busy", busy, 0);
            check("R10 sync_req", sync_req, 0);
            check("R10 illegal", illegal, 0);
        end
        check("R10 no strobe", we_count - base, 0);
    endtask

    task automatic t_stray_ack();
        ack_sync();
        check("R11 sync_req", sync_req, 0);
        check("R11 done", done, 0);
        check("R11 busy", busy, 0);
        check("R11 ready", in_ready, 1);
    endtask

    initial begin
        #1;
        check("R1 pre", in_ready, 1);
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        @(negedge clk); rst_n = 1'b1;
        tick();
        t_reset();
        t_sync(1'b0);
        t_sync(1'b1);
        t_stray_ack();
        t_idle_bytes();
        t_write(6'h0F, 32'hA1B2C3D4);
        t_write(6'h00, 32'h00000001);
        t_write_rejected();
        t_clear_by_sync();
        t_unknown(8'h02);
        t_unknown(8'hBF);
        t_unknown(8'h00);
        t_write(6'h2A, 32'hFFFF0000);
        t_abort();
        t_halt_drop();
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(20 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  %0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule